// File: doc/BRIEF.md
# BT.656 Embedded Sync Decoder

The block accepts an 8-bit 4:2:2 video byte stream with embedded timing reference codes. It searches that stream for the four-byte reference sequence and checks the protection bits of the flag byte. From each code it accepts, it rebuilds discrete horizontal sync, vertical sync and field signals. The video bytes are delayed so that they leave the block in step with those signals. In the separate-sync output form the reference codes are replaced by a blanking value, and the video samples can be clamped to the limited range.

A mode input selects the pass-through form instead. In that form the original embedded stream is forwarded untouched. The pass-through form is only available when the input carries embedded codes. A second mode input declares that the input already arrives with separate sync lines. In that case those lines are carried through with the data, and the pass-through request has no effect. A polarity input selects whether the input is sampled on the rising or the falling clock edge.

Top module: `vid_sync_decoder`

## Requirements
- R1: A timing reference is the byte run FF, 00, 00, XY. In XY, bit 7 is 1, bit 6 is F, bit 5 is V, bit 4 is H, and bits 3..0 are the protection bits {V^H, F^H, F^V, F^V^H}. An accepted code sets hs_o to H, vs_o to V and fld_o to F.
- R2: A candidate whose XY byte has bit 7 clear or wrong protection bits is rejected. The sync state is unchanged, and its four bytes leave the block as ordinary data.
- R3: A byte sampled at clock edge k appears on data_o after rising edge k+5. The sync outputs beside it reflect every code accepted no later than the XY byte sampled at edge k+3. As a result, all four bytes of a code carry the new flags, and the byte just before its FF byte carries the old ones.
- R4: In the separate-sync output form, every byte of an accepted code is replaced on data_o by 8'h10.
- R5: When embed_out_i=1 and sep_in_i=0, data_o repeats the input bytes unchanged, including codes and regardless of full_range_i, and hs_o, vs_o and fld_o stay 0.
- R6: When sep_in_i=1, hs_o, vs_o and fld_o follow hs_i, vs_i and fld_i with the same latency as the data. Code detection is off, and embed_out_i is ignored.
- R7: In the separate-sync form with full_range_i=0, video bytes alternate chroma and luma. The first byte after a code, or after a byte whose hs_o is 1, is chroma. Chroma is clamped to 16..240 and luma to 16..235. With full_range_i=1, video bytes pass unchanged.
- R8: With neg_edge_i=1, data_i, hs_i, vs_i and fld_i are sampled on the falling clock edge, and latency is counted from the next rising edge. With neg_edge_i=0, they are sampled on the rising edge.
- R9: While rst_ni is low, data_o, hs_o, vs_o and fld_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| neg_edge_i | input | 1 | 1: sample inputs on the falling edge |
| sep_in_i | input | 1 | 1: input carries separate sync lines |
| embed_out_i | input | 1 | 1: forward embedded stream (embedded input only) |
| full_range_i | input | 1 | 1: full range, 0: limited range clamp |
| data_i | input | 8 | Input video byte |
| hs_i | input | 1 | Horizontal sync for separate-sync input |
| vs_i | input | 1 | Vertical sync for separate-sync input |
| fld_i | input | 1 | Field for separate-sync input |
| data_o | output | 8 | Output video byte |
| hs_o | output | 1 | Regenerated horizontal sync |
| vs_o | output | 1 | Regenerated vertical sync |
| fld_o | output | 1 | Regenerated field |

## Verification
The hardest case to produce is a correct FF, 00, 00 preamble followed by a flag byte that is almost valid. Examples are a flag byte with one flag flipped against its protection bits, or one with the marker bit cleared. The bench builds lines in which such near-misses sit between valid codes, so the held sync state stays visible across them. Falling-edge sampling is only observable if the input changes between the two edges. The stimulus therefore places the real byte before the falling edge and its complement before the rising edge.

// File: rtl/vsd_pkg.sv
`timescale 1ns/1ps
package vsd_pkg;
  typedef struct packed {
    logic trs;
    logic hs;
    logic vs;
    logic fld;
  } vsd_tag_t;

  // protection nibble for a given flag set
  function automatic logic [3:0] vsd_prot(input logic f, input logic v, input logic h);
    vsd_prot = {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/vsd_edge_capture.sv
`timescale 1ns/1ps
module vsd_edge_capture #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         neg_edge_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= neg_edge_i ? neg_q : d_i;
  end
endmodule

// File: rtl/vsd_trs_detect.sv
`timescale 1ns/1ps
module vsd_trs_detect #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] byte_i,
  output logic          hit_o,
  output logic          f_o,
  output logic          v_o,
  output logic          h_o
);
  localparam int unsigned PRE_LEN = 3;

  logic [DW-1:0] hist_q [PRE_LEN];
  logic          pre_ok;
  logic          mark;
  logic [3:0]    prot;

  // hist_q[0] is the newest byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PRE_LEN; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= byte_i;
      for (int i = 1; i < PRE_LEN; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  assign pre_ok = (hist_q[PRE_LEN-1] == '1) && (hist_q[1] == '0) && (hist_q[0] == '0);
  assign mark   = byte_i[DW-1];
  assign f_o    = byte_i[DW-2];
  assign v_o    = byte_i[DW-3];
  assign h_o    = byte_i[DW-4];
  assign prot   = byte_i[DW-5 -: 4];
  assign hit_o  = en_i && pre_ok && mark && (prot == vsd_pkg::vsd_prot(f_o, v_o, h_o));

  // a preamble cannot overlap the previous code's bytes
  assert_hit_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (!$past(hit_o) && !$past(hit_o, 2) && !$past(hit_o, 3)));
endmodule

// File: rtl/vsd_sync_track.sv
`timescale 1ns/1ps
module vsd_sync_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic f_i,
  input  logic v_i,
  input  logic h_i,
  output logic h_o,
  output logic v_o,
  output logic f_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= 1'b0;
      v_o <= 1'b0;
      f_o <= 1'b0;
    end else if (hit_i) begin
      h_o <= h_i;
      v_o <= v_i;
      f_o <= f_i;
    end
  end

  assert_take_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (h_o == $past(h_i) && v_o == $past(v_i) && f_o == $past(f_i)));

  assert_hold_on_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable({h_o, v_o, f_o}));
endmodule

// File: rtl/vsd_align.sv
`timescale 1ns/1ps
module vsd_align #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     byte_i,
  input  vsd_pkg::vsd_tag_t tag_i,
  input  logic              hit_i,
  output logic [DW-1:0]     byte_o,
  output vsd_pkg::vsd_tag_t tag_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [DW-1:0]     b_q;
    logic [DW-1:0]     b_d;
    vsd_pkg::vsd_tag_t t_q;
    vsd_pkg::vsd_tag_t t_d;

    if (s == 0) begin : g_head
      assign b_d = byte_i;
      assign t_d = tag_i;
    end else begin : g_body
      assign b_d = g_stage[s-1].b_q;
      assign t_d = g_stage[s-1].t_q;
    end

    // a hit marks every byte of the code still in flight
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_q <= '0;
        t_q <= '0;
      end else begin
        b_q <= b_d;
        t_q <= '{trs: t_d.trs | hit_i, hs: t_d.hs, vs: t_d.vs, fld: t_d.fld};
      end
    end
  end

  assign byte_o = g_stage[DEPTH-1].b_q;
  assign tag_o  = g_stage[DEPTH-1].t_q;

  assert_code_marked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> tag_o.trs);
endmodule

// File: rtl/vsd_out_fmt.sv
`timescale 1ns/1ps
module vsd_out_fmt #(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sep_in_i,
  input  logic              embed_out_i,
  input  logic              full_range_i,
  input  logic [DW-1:0]     byte_i,
  input  vsd_pkg::vsd_tag_t tag_i,
  input  logic              st_h_i,
  input  logic              st_v_i,
  input  logic              st_f_i,
  output logic [DW-1:0]     data_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic              fld_o
);
  localparam logic [DW-1:0] LO    = DW'(16)  << (DW - 8);
  localparam logic [DW-1:0] Y_HI  = DW'(235) << (DW - 8);
  localparam logic [DW-1:0] C_HI  = DW'(240) << (DW - 8);
  localparam logic [DW-1:0] BLANK = DW'(16)  << (DW - 8);

  logic          phase_q;  // 1: current byte is luma
  logic          embed;
  logic          hs_n, vs_n, fld_n;
  logic [DW-1:0] hi, lim, d_n;

  always_comb begin
    embed = embed_out_i & ~sep_in_i;
    hs_n  = sep_in_i ? tag_i.hs  : st_h_i;
    vs_n  = sep_in_i ? tag_i.vs  : st_v_i;
    fld_n = sep_in_i ? tag_i.fld : st_f_i;
    hi    = phase_q ? Y_HI : C_HI;
    lim   = (byte_i < LO) ? LO : ((byte_i > hi) ? hi : byte_i);
    if (embed)              d_n = byte_i;
    else if (tag_i.trs)     d_n = BLANK;
    else if (!full_range_i) d_n = lim;
    else                    d_n = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      hs_o    <= 1'b0;
      vs_o    <= 1'b0;
      fld_o   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      data_o  <= d_n;
      hs_o    <= hs_n  & ~embed;
      vs_o    <= vs_n  & ~embed;
      fld_o   <= fld_n & ~embed;
      phase_q <= (tag_i.trs | hs_n) ? 1'b0 : ~phase_q;
    end
  end

  assert_embed_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (embed_out_i && !sep_in_i) |=> (!hs_o && !vs_o && !fld_o));

  assert_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_range_i && !(embed_out_i && !sep_in_i)) |=> (data_o >= LO && data_o <= C_HI));
endmodule

// File: rtl/vid_sync_decoder.sv
`timescale 1ns/1ps
module vid_sync_decoder #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          neg_edge_i,
  input  logic          sep_in_i,
  input  logic          embed_out_i,
  input  logic          full_range_i,
  input  logic [DW-1:0] data_i,
  input  logic          hs_i,
  input  logic          vs_i,
  input  logic          fld_i,
  output logic [DW-1:0] data_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic          fld_o
);
  localparam int unsigned SYNC_W      = 3;
  localparam int unsigned CAP_W       = DW + SYNC_W;
  localparam int unsigned ALIGN_DEPTH = 4;  // preamble plus flag byte

  logic [CAP_W-1:0]  cap_d, cap_q;
  logic [DW-1:0]     byte_q, al_byte;
  vsd_pkg::vsd_tag_t tag_in, al_tag;
  logic              hit, xf, xv, xh;
  logic              st_h, st_v, st_f;

  assign cap_d  = {data_i, hs_i, vs_i, fld_i};
  assign byte_q = cap_q[CAP_W-1 -: DW];
  assign tag_in = '{trs: 1'b0, hs: cap_q[2], vs: cap_q[1], fld: cap_q[0]};

  vsd_edge_capture #(.W(CAP_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .neg_edge_i (neg_edge_i),
    .d_i        (cap_d),
    .q_o        (cap_q)
  );

  vsd_trs_detect #(.DW(DW)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~sep_in_i),
    .byte_i (byte_q),
    .hit_o  (hit),
    .f_o    (xf),
    .v_o    (xv),
    .h_o    (xh)
  );

  vsd_sync_track u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .f_i    (xf),
    .v_i    (xv),
    .h_i    (xh),
    .h_o    (st_h),
    .v_o    (st_v),
    .f_o    (st_f)
  );

  vsd_align #(.DW(DW), .DEPTH(ALIGN_DEPTH)) u_aln (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byte_i (byte_q),
    .tag_i  (tag_in),
    .hit_i  (hit),
    .byte_o (al_byte),
    .tag_o  (al_tag)
  );

  vsd_out_fmt #(.DW(DW)) u_fmt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sep_in_i     (sep_in_i),
    .embed_out_i  (embed_out_i),
    .full_range_i (full_range_i),
    .byte_i       (al_byte),
    .tag_i        (al_tag),
    .st_h_i       (st_h),
    .st_v_i       (st_v),
    .st_f_i       (st_f),
    .data_o       (data_o),
    .hs_o         (hs_o),
    .vs_o         (vs_o),
    .fld_o        (fld_o)
  );
endmodule

// File: tb/tb_vid_sync_decoder.sv
`timescale 1ns/1ps
module tb_vid_sync_decoder;
  localparam int LAT  = 6;
  localparam int MAXN = 256;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       neg_edge_i = 1'b0, sep_in_i = 1'b0, embed_out_i = 1'b0, full_range_i = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic       hs_i = 1'b0, vs_i = 1'b0, fld_i = 1'b0;
  logic [7:0] data_o;
  logic       hs_o, vs_o, fld_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] s_b    [MAXN];
  logic [2:0] s_sync [MAXN];
  logic [7:0] e_b    [MAXN];
  logic [2:0] e_sync [MAXN];
  int         n;
  logic       m_h, m_v, m_f, ph;
  logic [2:0] g_sync;

  always #2 clk_i = ~clk_i;

  vid_sync_decoder dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .neg_edge_i(neg_edge_i), .sep_in_i(sep_in_i),
    .embed_out_i(embed_out_i), .full_range_i(full_range_i), .data_i(data_i),
    .hs_i(hs_i), .vs_i(vs_i), .fld_i(fld_i),
    .data_o(data_o), .hs_o(hs_o), .vs_o(vs_o), .fld_o(fld_o)
  );

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // append one byte with its expected output, per R3..R7
  task automatic put(input logic [7:0] b, input logic trs);
    logic [2:0] es;
    logic [7:0] ed, hi;
    logic       hsrc;
    logic       emb;
    emb  = embed_out_i && !sep_in_i;
    hsrc = sep_in_i ? g_sync[2] : m_h;
    if (emb)           es = 3'b000;
    else if (sep_in_i) es = g_sync;
    else               es = {m_h, m_v, m_f};
    hi = ph ? 8'd235 : 8'd240;
    if (emb)                ed = b;
    else if (trs)           ed = 8'h10;
    else if (!full_range_i) ed = (b < 8'd16) ? 8'd16 : ((b > hi) ? hi : b);
    else                    ed = b;
    s_b[n] = b; s_sync[n] = g_sync; e_b[n] = ed; e_sync[n] = es;
    n++;
    ph = (trs || hsrc) ? 1'b0 : ~ph;
  endtask

  task automatic put_code(input logic f, input logic v, input logic h);
    logic t;
    t = !sep_in_i;
    if (t) begin m_h = h; m_v = v; m_f = f; end
    put(8'hFF, t); put(8'h00, t); put(8'h00, t); put(xy(f, v, h), t);
  endtask

  task automatic put_bad(input logic [7:0] x);
    put(8'hFF, 1'b0); put(8'h00, 1'b0); put(8'h00, 1'b0); put(x, 1'b0);
  endtask

  task automatic put_run(input logic [7:0] first, input int cnt, input logic [7:0] step);
    for (int k = 0; k < cnt; k++) put(first + 8'(k) * step, 1'b0);
  endtask

  task automatic start(input logic ne, input logic si, input logic eo, input logic fr);
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    neg_edge_i = ne; sep_in_i = si; embed_out_i = eo; full_range_i = fr;
    data_i = 8'h00; {hs_i, vs_i, fld_i} = 3'b000;
    n = 0; m_h = 0; m_v = 0; m_f = 0; ph = 0; g_sync = 3'b000;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic play(input string req);
    for (int e = 0; e < n + LAT; e++) begin
      @(posedge clk_i); #1;
      if (e >= LAT) begin
        int i;
        i = e - LAT;
        checks++;
        if (data_o !== e_b[i] || {hs_o, vs_o, fld_o} !== e_sync[i]) begin
          errors++;
          $display("FAIL %s byte %0d actual data=%h hvf=%b expected data=%h hvf=%b",
                   req, i, data_o, {hs_o, vs_o, fld_o}, e_b[i], e_sync[i]);
        end
      end
      if (e < n) {data_i, hs_i, vs_i, fld_i} = {s_b[e], s_sync[e]};
      else       {data_i, hs_i, vs_i, fld_i} = 11'h0;
      if (neg_edge_i) begin
        @(negedge clk_i); #1;
        {data_i, hs_i, vs_i, fld_i} = ~{data_i, hs_i, vs_i, fld_i};
      end
    end
  endtask

  task automatic test_reset_r9();
    start(1'b0, 1'b0, 1'b0, 1'b1);
    rst_ni = 1'b0;
    data_i = 8'hA5; {hs_i, vs_i, fld_i} = 3'b111;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); #1;
      checks++;
      if (data_o !== 8'h00 || {hs_o, vs_o, fld_o} !== 3'b000) begin
        errors++;
        $display("FAIL R9 actual data=%h hvf=%b expected data=00 hvf=000",
                 data_o, {hs_o, vs_o, fld_o});
      end
    end
    rst_ni = 1'b1;
  endtask

  task automatic test_lines();
    start(1'b0, 1'b0, 1'b0, 1'b1);
    put(8'h80, 1'b0); put(8'h10, 1'b0);
    put_code(0, 0, 1); put_run(8'h80, 6, 8'h00);
    put_code(0, 0, 0); put_run(8'h20, 8, 8'h11);
    put_code(0, 1, 1); put_run(8'h10, 4, 8'h00);
    put_code(0, 1, 0); put_run(8'h40, 4, 8'h05);
    put_code(1, 1, 1); put_run(8'h80, 2, 8'h00);
    put_code(1, 0, 0); put_run(8'h33, 4, 8'h07);
    play("R1 R3 R4 codes");
  endtask

  task automatic test_bad_codes_r2();
    start(1'b0, 1'b0, 1'b0, 1'b1);
    put_code(0, 0, 1); put_run(8'h80, 4, 8'h00);
    put_bad(8'h81);                  // prot 0001 for F=V=H=0
    put_run(8'h50, 2, 8'h01);
    put_bad(8'h2B);                  // marker bit 7 cleared
    put_run(8'h60, 2, 8'h01);
    put_bad(8'hC0);                  // F flipped against prot
    put_run(8'h70, 2, 8'h01);
    put_code(0, 0, 0); put_run(8'h22, 4, 8'h03);
    play("R2 rejected code");
  endtask

  task automatic test_embed_r5();
    start(1'b0, 1'b0, 1'b1, 1'b0);
    put_code(0, 0, 1); put_run(8'h80, 4, 8'h00);
    put_code(1, 1, 0); put(8'h00, 1'b0); put(8'hFE, 1'b0); put(8'h05, 1'b0); put(8'hF9, 1'b0);
    put_code(1, 1, 1); put_run(8'h10, 2, 8'h00);
    play("R5 pass-through");
  endtask

  task automatic test_limited_r7();
    start(1'b0, 1'b0, 1'b0, 1'b0);
    put_code(0, 0, 0);
    put(8'h00, 1'b0); put(8'hFF, 1'b0); put(8'hF8, 1'b0); put(8'h08, 1'b0);
    put(8'h80, 1'b0); put(8'h50, 1'b0); put(8'hF0, 1'b0); put(8'hF0, 1'b0);
    put_code(0, 0, 1);
    put(8'h05, 1'b0); put(8'hF5, 1'b0); put(8'hF5, 1'b0);
    put_code(0, 0, 0);
    put(8'hFE, 1'b0); put(8'hFE, 1'b0); put(8'h02, 1'b0);
    play("R7 limited range");
  endtask

  task automatic test_sep_in_r6();
    start(1'b0, 1'b1, 1'b1, 1'b1);
    g_sync = 3'b100; put_run(8'h80, 3, 8'h00);
    put_code(0, 0, 0);               // arrives as plain data here
    g_sync = 3'b011; put_run(8'h30, 4, 8'h09);
    g_sync = 3'b101; put_code(0, 1, 1);
    g_sync = 3'b000; put_run(8'h44, 3, 8'h01);
    play("R6 separate-sync input");
  endtask

  task automatic test_falling_r8();
    start(1'b1, 1'b0, 1'b0, 1'b1);
    put_code(0, 0, 1); put_run(8'h80, 4, 8'h00);
    put_code(0, 0, 0); put_run(8'h21, 6, 8'h0D);
    put_code(1, 1, 1); put_run(8'h10, 2, 8'h00);
    play("R8 falling edge");
  endtask

  initial begin
    test_reset_r9();
    test_lines();
    test_bad_codes_r2();
    test_embed_r5();
    test_limited_r7();
    test_sep_in_r6();
    test_falling_r8();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule